// File: doc/BRIEF.md
# FSK Two-Tone Subcarrier Encoder

This block turns a serial NRZ bit stream into the on/off modulator control for a field-powered transponder. It runs on the clock recovered from the reader's field, one tick per RF period. Each bit is sent as a square subcarrier. A logic 0 uses RF/10, and a logic 1 uses RF/8. The nominal bit time is 50 RF periods.

Fifty is not a whole number of RF/8 cycles. Because of this, successive logic-1 bits take turns between a short length (48 clocks) and a long length (52 clocks). The mean bit time stays at 50, and the reader's decoder sees no glitch. Logic-0 bits always last 50 clocks and do not move the short/long turn.

The bit source follows a one-signal request handshake. The encoder raises `bit_req` during the final clock of the current bit. It takes `data_in` on the clock edge that ends that clock. The subcarrier restarts in its high half at every bit boundary.

Top module: `fsk2_tone_enc`

## Requirements
- R1: In the first clock after reset, `bit_req` is 1 and `mod_out` is 0, before any bit has been taken.
- R2: A logic-0 bit lasts exactly 50 clocks. During it, `mod_out` is 1 for 5 clocks, then 0 for 5 clocks, repeating from the bit's first clock.
- R3: A logic-1 bit drives `mod_out` as 1 for 4 clocks, then 0 for 4 clocks, repeating from the bit's first clock.
- R4: Logic-1 bits alternate in length: 48, 52, 48, 52, and so on. The first logic-1 bit after reset is 48 clocks, so any two successive ones together take 100 clocks.
- R5: Logic-0 bits placed between logic-1 bits do not change the short/long alternation of the ones.
- R6: `bit_req` is 1 exactly on the last clock of each bit. `data_in` is sampled on the rising edge that ends that clock, and the new bit starts on the next clock.
- R7: Every bit starts with `mod_out` at 1, whatever level the previous bit ended on. After a long logic-1 bit, for example, the high level continues through the boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RF-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 1 | Next NRZ bit, sampled when `bit_req` is high |
| bit_req | output | 1 | High on the last clock of a bit (and after reset): next bit is taken at the following edge |
| mod_out | output | 1 | Modulator control level, 1 = switch on |

## Verification
The bench builds the encoder with its default parameters: a 50-clock nominal bit, a swing of 2, and half-periods of 4 and 5 clocks. These values make the 52-clock one end in a high half. That exposes the high run of 9 clocks across a boundary. It also leaves the 48-clock one ending low, so both boundary cases of R7 are reached. Sequences of several ones, with zeros between them, and a reset after an odd count of ones drive the alternation through both phases and back to its reset value.

// File: rtl/fsk2_tone_enc.sv
module fsk2_tone_enc #(
  parameter int BIT_CLKS  = 50,
  parameter int SWING     = 2,
  parameter int ONE_HALF  = 4,
  parameter int ZERO_HALF = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  output logic bit_req,
  output logic mod_out
);
  localparam int LONG_CLKS  = BIT_CLKS + SWING;
  localparam int SHORT_CLKS = BIT_CLKS - SWING;
  localparam int CW = $clog2(LONG_CLKS + 1);
  localparam int MAX_HALF = (ONE_HALF > ZERO_HALF) ? ONE_HALF : ZERO_HALF;
  localparam int PW = $clog2(2 * MAX_HALF + 1);

  logic          started;
  logic          cur_bit;
  logic          cur_long;
  logic          long_nxt;
  logic [CW-1:0] cnt;
  logic [PW-1:0] ph;
  logic [CW-1:0] bit_len;
  logic [PW-1:0] half;
  logic          last;

  assign bit_len = !cur_bit  ? CW'(BIT_CLKS)
                 : cur_long  ? CW'(LONG_CLKS)
                 :             CW'(SHORT_CLKS);
  assign half    = cur_bit ? PW'(ONE_HALF) : PW'(ZERO_HALF);
  assign last    = (cnt == bit_len - CW'(1));
  assign bit_req = !started || last;
  assign mod_out = started && (ph < half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      cur_bit  <= 1'b0;
      cur_long <= 1'b0;
      long_nxt <= 1'b0;
      cnt      <= '0;
      ph       <= '0;
    end else if (bit_req) begin
      started <= 1'b1;
      cur_bit <= data_in;
      cnt     <= '0;
      ph      <= '0;
      if (data_in) begin
        cur_long <= long_nxt;
        long_nxt <= ~long_nxt;
      end
    end else begin
      cnt <= cnt + CW'(1);
      ph  <= (ph == (half << 1) - PW'(1)) ? '0 : ph + PW'(1);
    end
  end
endmodule

module fsk2_tone_enc_chk #(
  parameter int BIT_CLKS  = 50,
  parameter int SWING     = 2,
  parameter int ONE_HALF  = 4,
  parameter int ZERO_HALF = 5
) (
  input logic clk,
  input logic rst_n,
  input logic bit_req,
  input logic mod_out
);
  localparam int MAX_HALF = (ONE_HALF > ZERO_HALF) ? ONE_HALF : ZERO_HALF;
  int gap;
  int hi_run;
  int lo_run;
  logic seen_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= 0; hi_run <= 0; lo_run <= 0; seen_req <= 1'b0;
    end else begin
      gap    <= bit_req ? 1 : gap + 1;
      hi_run <= mod_out ? hi_run + 1 : 0;
      lo_run <= mod_out ? 0 : lo_run + 1;
      if (bit_req) seen_req <= 1'b1;
    end
  end

  p_restart_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> mod_out);

  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> !bit_req);

  p_bit_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && seen_req) |-> (gap == BIT_CLKS - SWING || gap == BIT_CLKS ||
                              gap == BIT_CLKS + SWING));

  p_high_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_out |-> (hi_run < ONE_HALF + ZERO_HALF));

  p_low_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_out |-> (lo_run < MAX_HALF));
endmodule

bind fsk2_tone_enc fsk2_tone_enc_chk #(
  .BIT_CLKS(BIT_CLKS), .SWING(SWING), .ONE_HALF(ONE_HALF), .ZERO_HALF(ZERO_HALF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_req(bit_req), .mod_out(mod_out)
);

// File: tb/sim_fsk2_tone_enc.sv
module sim_fsk2_tone_enc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_in = 1'b0;
  logic bit_req;
  logic mod_out;
  int checks = 0;
  int errors = 0;
  logic seq [16];

  always #5 clk = ~clk;

  fsk2_tone_enc u0 (.clk(clk), .rst_n(rst_n), .data_in(data_in),
                    .bit_req(bit_req), .mod_out(mod_out));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // applies reset, then checks R1 in the first cycle
  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 bit_req after reset", int'(bit_req), 1);
    chk("R1 mod_out after reset", int'(mod_out), 0);
  endtask

  // sends seq[0..n-1] and checks each clock against the requirement model
  task automatic send(input int n, input string name);
    bit alt = 1'b0;
    data_in = seq[0];
    for (int k = 0; k < n; k++) begin
      int len;
      int hf;
      if (seq[k]) begin
        len = alt ? 52 : 48;  // R4, R5
        alt = ~alt;
        hf = 4;               // R3
      end else begin
        len = 50;             // R2
        hf = 5;
      end
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        chk({name, seq[k] ? " R3 mod_out one" : " R2 mod_out zero"},
            int'(mod_out), ((c % (2 * hf)) < hf) ? 1 : 0);
        if (c == 0) chk({name, " R7 bit starts high"}, int'(mod_out), 1);
        chk({name, " R6 bit_req timing"}, int'(bit_req), (c == len - 1) ? 1 : 0);
        if (c == len - 1) data_in = (k + 1 < n) ? seq[k + 1] : 1'b0;
      end
    end
  endtask

  task automatic t_zeros();
    do_reset();
    for (int i = 0; i < 3; i++) seq[i] = 1'b0;
    send(3, "zeros");
  endtask

  task automatic t_ones();
    do_reset();
    for (int i = 0; i < 5; i++) seq[i] = 1'b1;
    send(5, "ones_alt_R4");
  endtask

  task automatic t_interleave();
    do_reset();
    seq[0] = 1; seq[1] = 0; seq[2] = 1; seq[3] = 0; seq[4] = 0;
    seq[5] = 1; seq[6] = 1; seq[7] = 0;
    send(8, "interleave_R5");
  endtask

  task automatic t_reset_restart();
    do_reset();
    for (int i = 0; i < 3; i++) seq[i] = 1'b1;
    send(3, "odd_ones");
    do_reset();
    seq[0] = 1; seq[1] = 1; seq[2] = 0;
    send(3, "after_reset_R4");
  endtask

  task automatic t_r1_hold();
    // with no edge yet taken, R1 state must be visible
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 bit_req in reset", int'(bit_req), 1);
    chk("R1 mod_out in reset", int'(mod_out), 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog R6 actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_r1_hold();
    t_zeros();
    t_ones();
    t_interleave();
    t_reset_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule